// File: doc/BRIEF.md
# Read-Protection Level Transition Controller

This block keeps the active read-protection level of an on-chip nonvolatile memory. It also holds a pending option set. Software writes a requested level, a protect-on-regression flag and an optional code-protected page range into a pending register through an option write port. None of it takes effect until a load strobe arrives. Levels are encoded 0, 1 and 2. Level 2 is final: once it is active, the level never changes again.

A load that moves the level from 1 down to 0 is a regression. A regression starts an erase walk over main memory. The walk visits pages in ascending order and issues one page-erase request at a time toward a memory model. Each request waits for its acknowledge. Whether a page is erased depends on two things: the active flag, and whether the page index lies inside the protected range. A one-cycle backup-clear pulse is sent when the walk will erase at least one page. When the walk ends, the level becomes 0. The other options keep their earlier values. Code protection is dropped only when the erase was full.

Top module: `protLevelCtrl`

## Requirements
- R1: Once level 2 is active, the level stays 2. Any option write made while at level 2 is ignored and sets the error flag.
- R2: A written level does not change `curLevel` until `loadStrobe` is sampled high. The level field encodes 0, 1 and 2 directly. The value 3 is illegal.
- R3: A load that is not a 1-to-0 regression makes the whole pending option set active at that edge. This covers 0→1 and 0→2. No page is erased and `backupClr` does not pulse.
- R4: On a 1-to-0 regression, every page is erased if the active flag is set or no protected range is enabled. In that case `protActive` falls to 0 when the walk ends.
- R5: On a 1-to-0 regression with the flag clear and a range enabled, only pages whose index lies outside [start, end] (inclusive) are erased. The range stays active.
- R6: If the enabled range covers pages 0 to NUM_PAGES-1 and the flag is clear, a regression erases no page and sends no backup-clear pulse. The level still becomes 0.
- R7: During a regression, `busy` is high and `eraseReq` is held with a stable `erasePage` until `eraseAck`. Pages are requested in strictly ascending order. `curLevel` becomes 0 only after the last page.
- R8: A write is rejected if it names level 3 or, with the range enabled, gives start > end or end ≥ NUM_PAGES. A rejected write leaves the pending set unchanged and sets a sticky error flag. A pulse on `errClr` clears the flag.
- R9: Each regression that erases at least one page produces exactly one one-cycle `backupClr` pulse.
- R10: After reset, the level is 0, protection is off, and `busy`, `errFlag`, `eraseReq` and `backupClr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| optWrEn | input | 1 | Option write strobe |
| optLevel | input | 2 | Requested level |
| optFlag | input | 1 | Protect-on-regression flag |
| optRangeValid | input | 1 | Enables the protected page range |
| optRangeStart | input | PAGE_W | First protected page |
| optRangeEnd | input | PAGE_W | Last protected page (inclusive) |
| errClr | input | 1 | Write-one-to-clear for the error flag |
| loadStrobe | input | 1 | Option load command |
| eraseReq | output | 1 | Page erase request |
| erasePage | output | PAGE_W | Page index of the request |
| eraseAck | input | 1 | Page erase acknowledge |
| backupClr | output | 1 | Backup register clear pulse |
| curLevel | output | 2 | Active protection level |
| protActive | output | 1 | Protected range in force |
| busy | output | 1 | Erase walk in progress |
| errFlag | output | 1 | Sticky rejected-write flag |

## Verification
The handshake assertions assume the memory model raises `eraseAck` only while `eraseReq` is high, and for a single cycle per request. The bench's model raises the acknowledge one cycle after it sees a request and drops it on the next cycle. The level-change check assumes that loads and writes come only when `busy` is low. The stimulus therefore waits for `busy` to fall before each new write or load. All inputs change on the falling edge, so every strobe is a single clean sample.

// File: rtl/protLvlPkg.sv
package protLvlPkg;

  typedef enum logic {
    ST_IDLE,
    ST_WALK
  } walkState_t;

  typedef struct packed {
    logic capturePend;
    logic flagErr;
    logic applyLoad;
    logic startErase;
    logic advPage;
    logic finishErase;
  } ctlStrobes_t;

endpackage

// File: rtl/protLvlControl.sv
module protLvlControl
  import protLvlPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        optWrEn,
  input  logic        loadStrobe,
  input  logic        eraseAck,
  input  logic        reqIllegal,
  input  logic        atLevel2,
  input  logic        regression,
  input  logic        pageSkip,
  input  logic        lastPage,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        eraseReq
);

  walkState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    eraseReq  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (optWrEn) begin
          if (reqIllegal) ctl.flagErr     = 1'b1;
          else            ctl.capturePend = 1'b1;
        end
        if (loadStrobe && !atLevel2) begin
          if (regression) begin
            ctl.startErase = 1'b1;
            stateNext      = ST_WALK;
          end else begin
            ctl.applyLoad = 1'b1;
          end
        end
      end
      ST_WALK: begin
        eraseReq = !pageSkip;
        if (pageSkip || eraseAck) begin
          if (lastPage) begin
            ctl.finishErase = 1'b1;
            stateNext       = ST_IDLE;
          end else begin
            ctl.advPage = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state == ST_WALK);

  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |-> busy); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (eraseReq && !eraseAck) |=> eraseReq); // R7

endmodule

// File: rtl/protLvlDatapath.sv
module protLvlDatapath
  import protLvlPkg::*;
#(
  parameter int NUM_PAGES = 16,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              errClr,
  input  logic [1:0]        optLevel,
  input  logic              optFlag,
  input  logic              optRangeValid,
  input  logic [PAGE_W-1:0] optRangeStart,
  input  logic [PAGE_W-1:0] optRangeEnd,
  output logic              reqIllegal,
  output logic              atLevel2,
  output logic              regression,
  output logic              pageSkip,
  output logic              lastPage,
  output logic [1:0]        curLevel,
  output logic              protActive,
  output logic              errFlag,
  output logic              backupClr,
  output logic [PAGE_W-1:0] erasePage
);

  localparam logic [PAGE_W-1:0] LAST_IDX = PAGE_W'(NUM_PAGES - 1);
  localparam logic [PAGE_W:0]   PAGE_LIM = (PAGE_W + 1)'(NUM_PAGES);

  logic [1:0]        pendLevel;
  logic              pendFlag, pendValid;
  logic [PAGE_W-1:0] pendStart, pendEnd;
  logic              actFlag, actValid;
  logic [PAGE_W-1:0] actStart, actEnd;
  logic              fullErase;
  logic [PAGE_W-1:0] pageCnt;
  logic              fullNow, anyErase, pageInRange, badRange;

  assign badRange    = optRangeValid &&
                       ((optRangeStart > optRangeEnd) || ({1'b0, optRangeEnd} >= PAGE_LIM));
  assign atLevel2    = (curLevel == 2'd2);
  assign reqIllegal  = atLevel2 || (optLevel == 2'd3) || badRange;
  assign regression  = (curLevel == 2'd1) && (pendLevel == 2'd0);
  assign fullNow     = !actValid || actFlag;
  assign anyErase    = fullNow || (actStart != '0) || (actEnd != LAST_IDX);
  assign pageInRange = actValid && (pageCnt >= actStart) && (pageCnt <= actEnd);
  assign pageSkip    = !fullErase && pageInRange;
  assign lastPage    = (pageCnt == LAST_IDX);
  assign erasePage   = pageCnt;
  assign protActive  = actValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendLevel <= 2'd0;
      pendFlag  <= 1'b0;
      pendValid <= 1'b0;
      pendStart <= '0;
      pendEnd   <= '0;
    end else if (ctl.capturePend) begin
      pendLevel <= optLevel;
      pendFlag  <= optFlag;
      pendValid <= optRangeValid;
      pendStart <= optRangeStart;
      pendEnd   <= optRangeEnd;
    end else if (ctl.finishErase) begin
      pendFlag  <= actFlag;
      pendValid <= actValid && !fullErase;
      pendStart <= actStart;
      pendEnd   <= actEnd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLevel <= 2'd0;
      actFlag  <= 1'b0;
      actValid <= 1'b0;
      actStart <= '0;
      actEnd   <= '0;
    end else if (ctl.applyLoad) begin
      curLevel <= pendLevel;
      actFlag  <= pendFlag;
      actValid <= pendValid;
      actStart <= pendStart;
      actEnd   <= pendEnd;
    end else if (ctl.finishErase) begin
      curLevel <= 2'd0;
      if (fullErase) actValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullErase <= 1'b0;
      pageCnt   <= '0;
      backupClr <= 1'b0;
    end else begin
      backupClr <= ctl.startErase && anyErase;
      if (ctl.startErase) begin
        fullErase <= fullNow;
        pageCnt   <= '0;
      end else if (ctl.advPage) begin
        pageCnt <= pageCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               errFlag <= 1'b0;
    else if (ctl.flagErr)    errFlag <= 1'b1;
    else if (errClr)         errFlag <= 1'b0;
  end

  AST_LEVEL2_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (curLevel == 2'd2) |=> (curLevel == 2'd2)); // R1

  AST_BACKUP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    backupClr |=> !backupClr); // R9

endmodule

// File: rtl/protLevelCtrl.sv
module protLevelCtrl
  import protLvlPkg::*;
#(
  parameter int NUM_PAGES = 16,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              optWrEn,
  input  logic [1:0]        optLevel,
  input  logic              optFlag,
  input  logic              optRangeValid,
  input  logic [PAGE_W-1:0] optRangeStart,
  input  logic [PAGE_W-1:0] optRangeEnd,
  input  logic              errClr,
  input  logic              loadStrobe,
  output logic              eraseReq,
  output logic [PAGE_W-1:0] erasePage,
  input  logic              eraseAck,
  output logic              backupClr,
  output logic [1:0]        curLevel,
  output logic              protActive,
  output logic              busy,
  output logic              errFlag
);

  ctlStrobes_t ctl;
  logic reqIllegal, atLevel2, regression, pageSkip, lastPage;

  protLvlControl uControl (
    .clk        (clk),
    .rstN       (rstN),
    .optWrEn    (optWrEn),
    .loadStrobe (loadStrobe),
    .eraseAck   (eraseAck),
    .reqIllegal (reqIllegal),
    .atLevel2   (atLevel2),
    .regression (regression),
    .pageSkip   (pageSkip),
    .lastPage   (lastPage),
    .ctl        (ctl),
    .busy       (busy),
    .eraseReq   (eraseReq)
  );

  protLvlDatapath #(.NUM_PAGES(NUM_PAGES)) uDatapath (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .errClr        (errClr),
    .optLevel      (optLevel),
    .optFlag       (optFlag),
    .optRangeValid (optRangeValid),
    .optRangeStart (optRangeStart),
    .optRangeEnd   (optRangeEnd),
    .reqIllegal    (reqIllegal),
    .atLevel2      (atLevel2),
    .regression    (regression),
    .pageSkip      (pageSkip),
    .lastPage      (lastPage),
    .curLevel      (curLevel),
    .protActive    (protActive),
    .errFlag       (errFlag),
    .backupClr     (backupClr),
    .erasePage     (erasePage)
  );

  AST_LEVEL_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (curLevel != $past(curLevel)) |-> ($past(loadStrobe) || $past(busy))); // R2

  AST_PAGE_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (eraseReq && eraseAck) |=> (!busy || (erasePage > $past(erasePage)))); // R7

  AST_REQ_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (eraseReq && !eraseAck) |=> $stable(erasePage)); // R7

  AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(optWrEn)); // R8

endmodule

// File: tb/protLevelCtrl_test.sv
module protLevelCtrl_test;

  localparam int NP = 16;

  typedef struct packed {
    logic [1:0]  lvl;
    logic        flag;
    logic        valid;
    logic [3:0]  rs;
    logic [3:0]  re;
    logic [1:0]  xLvl;
    logic        xErr;
    logic        xBk;
    logic        xProt;
    logic [15:0] xMask;
  } vec_t;

  // rows run in order; level 2 is entered last
  localparam vec_t VECS [13] = '{
    '{2'd1, 1'b0, 1'b1, 4'd4,  4'd7,  2'd1, 1'b0, 1'b0, 1'b1, 16'h0000}, // R3 raise
    '{2'd0, 1'b0, 1'b1, 4'd4,  4'd7,  2'd0, 1'b0, 1'b1, 1'b1, 16'hFF0F}, // R5 partial
    '{2'd1, 1'b1, 1'b1, 4'd2,  4'd3,  2'd1, 1'b0, 1'b0, 1'b1, 16'h0000}, // R3
    '{2'd0, 1'b1, 1'b1, 4'd2,  4'd3,  2'd0, 1'b0, 1'b1, 1'b0, 16'hFFFF}, // R4 flag set
    '{2'd1, 1'b0, 1'b0, 4'd0,  4'd0,  2'd1, 1'b0, 1'b0, 1'b0, 16'h0000}, // R3
    '{2'd0, 1'b0, 1'b0, 4'd0,  4'd0,  2'd0, 1'b0, 1'b1, 1'b0, 16'hFFFF}, // R4 no range
    '{2'd1, 1'b0, 1'b1, 4'd0,  4'd15, 2'd1, 1'b0, 1'b0, 1'b1, 16'h0000}, // R3
    '{2'd0, 1'b0, 1'b1, 4'd0,  4'd15, 2'd0, 1'b0, 1'b0, 1'b1, 16'h0000}, // R6 all kept
    '{2'd3, 1'b0, 1'b1, 4'd0,  4'd15, 2'd0, 1'b1, 1'b0, 1'b1, 16'h0000}, // R8 level 3
    '{2'd1, 1'b0, 1'b1, 4'd9,  4'd3,  2'd0, 1'b1, 1'b0, 1'b1, 16'h0000}, // R8 start>end
    '{2'd1, 1'b0, 1'b1, 4'd15, 4'd15, 2'd1, 1'b0, 1'b0, 1'b1, 16'h0000}, // R3
    '{2'd0, 1'b0, 1'b1, 4'd15, 4'd15, 2'd0, 1'b0, 1'b1, 1'b1, 16'h7FFF}, // R5 last page kept
    '{2'd2, 1'b0, 1'b0, 4'd0,  4'd0,  2'd2, 1'b0, 1'b0, 1'b0, 16'h0000}  // R3 0 to 2
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       optWrEn = 1'b0;
  logic [1:0] optLevel = 2'd0;
  logic       optFlag = 1'b0;
  logic       optRangeValid = 1'b0;
  logic [3:0] optRangeStart = '0;
  logic [3:0] optRangeEnd = '0;
  logic       errClr = 1'b0;
  logic       loadStrobe = 1'b0;
  logic       eraseReq;
  logic [3:0] erasePage;
  logic       eraseAck = 1'b0;
  logic       backupClr;
  logic [1:0] curLevel;
  logic       protActive;
  logic       busy;
  logic       errFlag;

  int nChecks = 0;
  int nFails = 0;
  int eraseCnt [NP];
  int backupCnt = 0;
  int orderErr = 0;
  int busyCycles = 0;
  int lastPg = -1;

  always #10 clk = ~clk; // 50 MHz

  protLevelCtrl #(.NUM_PAGES(NP)) uut (
    .clk(clk), .rstN(rstN), .optWrEn(optWrEn), .optLevel(optLevel),
    .optFlag(optFlag), .optRangeValid(optRangeValid),
    .optRangeStart(optRangeStart), .optRangeEnd(optRangeEnd),
    .errClr(errClr), .loadStrobe(loadStrobe), .eraseReq(eraseReq),
    .erasePage(erasePage), .eraseAck(eraseAck), .backupClr(backupClr),
    .curLevel(curLevel), .protActive(protActive), .busy(busy),
    .errFlag(errFlag)
  );

  // memory model: acknowledges one cycle after a request, for one cycle
  initial for (int i = 0; i < NP; i++) eraseCnt[i] = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      eraseAck = 1'b0;
    end else begin
      if (backupClr) backupCnt++;
      if (busy) busyCycles++;
      else lastPg = -1;
      if (eraseReq && !eraseAck) begin
        eraseAck = 1'b1;
        if (int'(erasePage) <= lastPg) orderErr++;
        lastPg = int'(erasePage);
        eraseCnt[erasePage]++;
      end else begin
        eraseAck = 1'b0;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic writeOpt(logic [1:0] lv, logic fl, logic va, logic [3:0] s, logic [3:0] e);
    optWrEn = 1'b1; optLevel = lv; optFlag = fl;
    optRangeValid = va; optRangeStart = s; optRangeEnd = e;
    @(negedge clk);
    optWrEn = 1'b0;
  endtask

  task automatic doLoad();
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runRow(int idx, vec_t v);
    int snap [NP];
    int bkSnap;
    int startLvl;
    logic [15:0] got;
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NP; i++) snap[i] = eraseCnt[i];
    bkSnap = backupCnt;
    startLvl = int'(curLevel);
    writeOpt(v.lvl, v.flag, v.valid, v.rs, v.re);
    chk($sformatf("R2 row %0d level before load", idx), int'(curLevel), startLvl);
    chk($sformatf("R8 row %0d error flag", idx), int'(errFlag), int'(v.xErr));
    doLoad();
    got = '0;
    for (int i = 0; i < NP; i++) got[i] = (eraseCnt[i] != snap[i]);
    chk($sformatf("R3 row %0d level after load", idx), int'(curLevel), int'(v.xLvl));
    chk($sformatf("R4 row %0d protection", idx), int'(protActive), int'(v.xProt));
    chk($sformatf("R5 row %0d erased pages", idx), int'(got), int'(v.xMask));
    chk($sformatf("R9 row %0d backup pulses", idx), backupCnt - bkSnap, int'(v.xBk));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishUp();
  end

  initial begin
    int bk0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 level", int'(curLevel), 0);
    chk("R10 busy", int'(busy), 0);
    chk("R10 error", int'(errFlag), 0);
    chk("R10 protect", int'(protActive), 0);
    chk("R10 request", int'(eraseReq), 0);
    chk("R10 backup", int'(backupClr), 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);

    for (int r = 0; r < 13; r++) runRow(r, VECS[r]);

    // R7 walk order and busy seen during regressions
    chk("R7 ascending order", orderErr, 0);
    chk("R7 busy during walk", int'(busyCycles > 0), 1);

    // R1 level 2 is final: a write is rejected and a load changes nothing
    bk0 = backupCnt;
    writeOpt(2'd0, 1'b1, 1'b0, 4'd0, 4'd0);
    chk("R1 error on write at level 2", int'(errFlag), 1);
    doLoad();
    chk("R1 level stays 2", int'(curLevel), 2);
    chk("R1 no backup clear", backupCnt - bk0, 0);
    chk("R1 not busy", int'(busy), 0);

    // R8 write-one-to-clear
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
    chk("R8 error cleared", int'(errFlag), 0);

    finishUp();
  end

endmodule